// File: doc/BRIEF.md
# Synthesizer Serial Control and Status Port

This block is the two-wire serial slave that sets up a frequency synthesizer and reports its health. A bus master addresses it with one of four device addresses, chosen by a 2-bit strap input, and then writes up to four configuration bytes. These bytes set the 17-bit main divide ratio, the reference divider select, the prescaler enable, the charge pump current, the auxiliary clock output select, the test mode and four open-collector port latches. A read returns one status byte. That byte packs a sticky power-on flag, the loop lock indication, the levels of three input-capable ports and the code of a five-level converter.

Both bus lines are brought into the system clock domain through a synchronizer. Edges and START/STOP conditions are detected there, so the system clock must run at least 16 times faster than SCL. That ratio covers both 100 kHz and 400 kHz bus rates. The open-drain SDA pin is modelled as a pull-low enable.

Every received byte is checked first and only then applied. The divide ratio spans three bytes, so it is held in a shadow register and reaches the live output in a single cycle once its last byte arrives. The divider therefore never sees a half-written ratio.

Top module: `synth_i2c_ctrl`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal 1,1,0,0,0 followed by `addr_sel_i[1]`, `addr_sel_i[0]`. The LSB is the read (1) or write (0) flag. A mismatching address gets no acknowledge, and the data bytes that follow it change no output.
- R2: Data byte 1 sets `presc_en_o` from bit 7, `cp_cur_o` from bits 6:5 and `ref_sel_o` from bits 4:1. These fields update as soon as byte 1 has been received.
- R3: Byte 1 bit 0, byte 2 and byte 3 form `main_ratio_o` bits 16, 15:8 and 7:0. All 17 bits change together, and only when byte 3 has been received. A transfer that stops earlier leaves the ratio unchanged.
- R4: Data byte 4 sets `port_pull_o` from bits 7:4, `aux_sel_o` from bits 3:2 and `test_mode_o` from bits 1:0.
- R5: Data bytes 1 to 4 of an addressed write are acknowledged. Any further byte in the same transfer is not acknowledged and has no effect on any output.
- R6: A read shifts out the status byte MSB first as {power-on flag, `lock_i`, `port_in_i[2]`, `port_in_i[1]`, `port_in_i[0]`, converter code[2:0]}. If the master acknowledges, a fresh status byte follows.
- R7: The converter code in the status byte equals `adc_code_i` for values 0 to 4. The values 5, 6 and 7 are reported as 4.
- R8: The power-on flag is 1 after reset. It clears at the acknowledge slot of the first status byte sent, and it stays 0 until the next reset.
- R9: During and after reset, all configuration outputs are 0 and `sda_oe_o` is 0.
- R10: After a STOP condition, `sda_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 16x SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| addr_sel_i | input | 2 | Device address strap |
| lock_i | input | 1 | Loop lock indication |
| port_in_i | input | 3 | Levels of the three input-capable ports |
| adc_code_i | input | 3 | Converter comparator result |
| main_ratio_o | output | 17 | Main divide ratio |
| ref_sel_o | output | 4 | Reference divider select |
| presc_en_o | output | 1 | Divide-by-two prescaler enable |
| cp_cur_o | output | 2 | Charge pump current select |
| aux_sel_o | output | 2 | Auxiliary clock output select |
| test_mode_o | output | 2 | Test mode select |
| port_pull_o | output | 4 | Open-collector port pull-low latches |

## Verification
The bench builds the block with its default parameters: the fixed 11000 address prefix and a two-stage line synchronizer. At these values every strap setting can be crossed with every address variant, and all eight converter codes can be swept together with eight port and lock patterns. Write frames with arithmetic ratio patterns, some of which set bit 16, check the field positions. Truncated frames, over-long frames and frames with a wrong address check the atomic ratio update and the no-effect cases.

// File: rtl/synth_i2c_pkg.sv
package synth_i2c_pkg;
  localparam int RATIO_W    = 17;
  localparam int DATA_BYTES = 4;
  localparam int IDX_W      = $clog2(DATA_BYTES + 1);
  localparam int WIDX_W     = $clog2(DATA_BYTES);
  localparam int PORT_N     = 4;
  localparam int IN_PORT_N  = 3;
  localparam int ADC_W      = 3;
  localparam int ADC_MAX    = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WRITE,
    ST_READ
  } bus_st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw, cur, prev;
  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '1;
      else         pipe_q <= {pipe_q[STAGES-1:0], raw[g]};
    end
    assign cur[g]  = pipe_q[STAGES-1];
    assign prev[g] = pipe_q[STAGES];
  end

  assign sda_s_o    = cur[0];
  assign scl_rise_o = cur[1] & ~prev[1];
  assign scl_fall_o = ~cur[1] & prev[1];
  // SDA edges while SCL holds high
  assign start_o    = cur[1] & prev[1] & prev[0] & ~cur[0];
  assign stop_o     = cur[1] & prev[1] & ~prev[0] & cur[0];
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import synth_i2c_pkg::*;
#(
  parameter logic [4:0] ADDR_BASE = 5'b11000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_sel_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [7:0]        status_i,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [WIDX_W-1:0] wr_idx_o,
  output logic [7:0]        wr_data_o,
  output logic              por_clr_o
);
  bus_st_e          st_q;
  logic [3:0]       bit_q;
  logic [6:0]       sh_q;
  logic [7:0]       tx_q;
  logic [IDX_W-1:0] idx_q;
  logic             ack_q, rw_q, slot_q, done_q;

  logic [7:0] rx_byte;
  logic       addr_hit, last_bit, ack_bit, idx_ok;

  assign rx_byte  = {sh_q, sda_s_i};
  assign addr_hit = rx_byte[7:1] == {ADDR_BASE, addr_sel_i};
  assign last_bit = scl_rise_i && (bit_q == 4'd7);
  assign ack_bit  = scl_rise_i && (bit_q == 4'd8);
  assign idx_ok   = idx_q < IDX_W'(DATA_BYTES);

  assign wr_en_o   = last_bit && (st_q == ST_WRITE) && idx_ok;
  assign wr_idx_o  = idx_q[WIDX_W-1:0];
  assign wr_data_o = rx_byte;
  assign por_clr_o = ack_bit && (st_q == ST_READ) && !done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      bit_q    <= '0;
      sh_q     <= '0;
      tx_q     <= '0;
      idx_q    <= '0;
      ack_q    <= 1'b0;
      rw_q     <= 1'b0;
      slot_q   <= 1'b0;
      done_q   <= 1'b0;
      sda_oe_o <= 1'b0;
    end else if (start_i) begin
      st_q     <= ST_ADDR;
      bit_q    <= '0;
      idx_q    <= '0;
      ack_q    <= 1'b0;
      slot_q   <= 1'b0;
      done_q   <= 1'b0;
      sda_oe_o <= 1'b0;
    end else if (stop_i) begin
      st_q     <= ST_IDLE;
      slot_q   <= 1'b0;
      sda_oe_o <= 1'b0;
    end else if (st_q != ST_IDLE) begin
      if (scl_rise_i) begin
        if (bit_q == 4'd8) begin
          // acknowledge slot
          bit_q  <= '0;
          slot_q <= 1'b1;
          case (st_q)
            ST_ADDR: st_q <= rw_q ? ST_READ : ST_WRITE;
            ST_READ: if (sda_s_i) done_q <= 1'b1;
            default: ;
          endcase
        end else begin
          bit_q <= bit_q + 4'd1;
          sh_q  <= rx_byte[6:0];
          if (bit_q == 4'd7) begin
            if (st_q == ST_ADDR) begin
              if (addr_hit) begin
                ack_q <= 1'b1;
                rw_q  <= sda_s_i;
              end else begin
                st_q <= ST_IDLE;
              end
            end else if (st_q == ST_WRITE) begin
              ack_q <= idx_ok;
              if (idx_ok) idx_q <= idx_q + IDX_W'(1);
            end
          end
        end
      end else if (scl_fall_i) begin
        if (slot_q) begin
          slot_q <= 1'b0;
          if (st_q == ST_READ && !done_q) begin
            tx_q     <= status_i;
            sda_oe_o <= ~status_i[7];
          end else begin
            sda_oe_o <= 1'b0;
          end
        end else if (bit_q == 4'd8) begin
          sda_oe_o <= (st_q == ST_READ) ? 1'b0 : ack_q;
        end else if (st_q == ST_READ && !done_q && bit_q != 4'd0) begin
          sda_oe_o <= ~tx_q[3'(4'd7 - bit_q)];
        end
      end
    end
  end
endmodule

// File: rtl/synth_cfg_regs.sv
module synth_cfg_regs
  import synth_i2c_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [WIDX_W-1:0]  wr_idx_i,
  input  logic [7:0]         wr_data_i,
  output logic [RATIO_W-1:0] ratio_o,
  output logic [3:0]         ref_sel_o,
  output logic               presc_en_o,
  output logic [1:0]         cp_cur_o,
  output logic [1:0]         aux_sel_o,
  output logic [1:0]         test_mode_o,
  output logic [PORT_N-1:0]  pull_o
);
  localparam int LO_W = 8;
  localparam int HI_W = RATIO_W - LO_W - 1;

  logic            sh_msb_q;
  logic [HI_W-1:0] sh_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_msb_q    <= 1'b0;
      sh_hi_q     <= '0;
      ratio_o     <= '0;
      ref_sel_o   <= '0;
      presc_en_o  <= 1'b0;
      cp_cur_o    <= '0;
      aux_sel_o   <= '0;
      test_mode_o <= '0;
      pull_o      <= '0;
    end else if (wr_en_i) begin
      case (wr_idx_i)
        WIDX_W'(0): begin
          presc_en_o <= wr_data_i[7];
          cp_cur_o   <= wr_data_i[6:5];
          ref_sel_o  <= wr_data_i[4:1];
          sh_msb_q   <= wr_data_i[0];
        end
        WIDX_W'(1): sh_hi_q <= wr_data_i[HI_W-1:0];
        WIDX_W'(2): ratio_o <= {sh_msb_q, sh_hi_q, wr_data_i};
        default: begin
          pull_o      <= wr_data_i[7:4];
          aux_sel_o   <= wr_data_i[3:2];
          test_mode_o <= wr_data_i[1:0];
        end
      endcase
    end
  end
endmodule

// File: rtl/synth_status.sv
module synth_status
  import synth_i2c_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 por_clr_i,
  input  logic                 lock_i,
  input  logic [IN_PORT_N-1:0] port_in_i,
  input  logic [ADC_W-1:0]     adc_code_i,
  output logic                 por_o,
  output logic [7:0]           status_o
);
  logic [ADC_W-1:0] adc_lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        por_o <= 1'b1;
    else if (por_clr_i) por_o <= 1'b0;
  end

  assign adc_lvl  = (adc_code_i > ADC_W'(ADC_MAX)) ? ADC_W'(ADC_MAX) : adc_code_i;
  assign status_o = {por_o, lock_i, port_in_i, adc_lvl};
endmodule

// File: rtl/synth_i2c_ctrl.sv
module synth_i2c_ctrl
  import synth_i2c_pkg::*;
#(
  parameter logic [4:0] ADDR_BASE   = 5'b11000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe_o,
  input  logic [1:0]           addr_sel_i,
  input  logic                 lock_i,
  input  logic [IN_PORT_N-1:0] port_in_i,
  input  logic [ADC_W-1:0]     adc_code_i,
  output logic [RATIO_W-1:0]   main_ratio_o,
  output logic [3:0]           ref_sel_o,
  output logic                 presc_en_o,
  output logic [1:0]           cp_cur_o,
  output logic [1:0]           aux_sel_o,
  output logic [1:0]           test_mode_o,
  output logic [PORT_N-1:0]    port_pull_o
);
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en, por_clr, por_flag;
  logic [WIDX_W-1:0] wr_idx;
  logic [7:0]        wr_data, status_byte;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_s_o    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_byte_engine #(.ADDR_BASE(ADDR_BASE)) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_sel_i (addr_sel_i),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .status_i   (status_byte),
    .sda_oe_o   (sda_oe_o),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data),
    .por_clr_o  (por_clr)
  );

  synth_cfg_regs u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en),
    .wr_idx_i    (wr_idx),
    .wr_data_i   (wr_data),
    .ratio_o     (main_ratio_o),
    .ref_sel_o   (ref_sel_o),
    .presc_en_o  (presc_en_o),
    .cp_cur_o    (cp_cur_o),
    .aux_sel_o   (aux_sel_o),
    .test_mode_o (test_mode_o),
    .pull_o      (port_pull_o)
  );

  synth_status u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .por_clr_i  (por_clr),
    .lock_i     (lock_i),
    .port_in_i  (port_in_i),
    .adc_code_i (adc_code_i),
    .por_o      (por_flag),
    .status_o   (status_byte)
  );
endmodule

// File: rtl/synth_i2c_chk.sv
module synth_i2c_chk
  import synth_i2c_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [WIDX_W-1:0]  wr_idx_i,
  input logic [RATIO_W-1:0] ratio_i,
  input logic [PORT_N-1:0]  pull_i,
  input logic               por_i,
  input logic [7:0]         status_i,
  input logic               stop_i,
  input logic               sda_oe_i
);
  AST_RATIO_ATOMIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_idx_i == WIDX_W'(2)) |=> $stable(ratio_i)); // R3
  AST_PULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_idx_i == WIDX_W'(3)) |=> $stable(pull_i)); // R4
  AST_POR_STAYS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_i |=> !por_i); // R8
  AST_ADC_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[2:0] <= 3'd4); // R7
  AST_STOP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_i); // R10
endmodule

bind synth_i2c_ctrl synth_i2c_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en),
  .wr_idx_i (wr_idx),
  .ratio_i  (main_ratio_o),
  .pull_i   (port_pull_o),
  .por_i    (por_flag),
  .status_i (status_byte),
  .stop_i   (stop_det),
  .sda_oe_i (sda_oe_o)
);

// File: tb/sim_synth_i2c_ctrl.sv
`timescale 1ns/1ps
module sim_synth_i2c_ctrl;
  localparam int Q = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        scl_m, sda_m, sda_bus;
  logic        sda_oe;
  logic [1:0]  addr_sel;
  logic        lock;
  logic [2:0]  pin, adc;
  logic [16:0] ratio;
  logic [3:0]  ref_sel, pull;
  logic        presc;
  logic [1:0]  cp, aux, test;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  logic [16:0] e_ratio;
  logic [3:0]  e_ref, e_pull;
  logic        e_presc;
  logic [1:0]  e_cp, e_aux, e_test;

  always #2.5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  synth_i2c_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .addr_sel_i(addr_sel), .lock_i(lock), .port_in_i(pin), .adc_code_i(adc),
    .main_ratio_o(ratio), .ref_sel_o(ref_sel), .presc_en_o(presc), .cp_cur_o(cp),
    .aux_sel_o(aux), .test_mode_o(test), .port_pull_o(pull)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b1; wait_q(); wait_q();
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_q();
      scl_m = 1'b1; wait_q(); wait_q();
      scl_m = 1'b0; wait_q();
    end
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    ack = ~sda_bus; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic get_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_q();
      scl_m = 1'b1; wait_q();
      b[i] = sda_bus; wait_q();
      scl_m = 1'b0;
    end
    wait_q();
    sda_m = ~mack; wait_q();
    scl_m = 1'b1; wait_q(); wait_q();
    scl_m = 1'b0; wait_q();
    sda_m = 1'b1;
  endtask

  task automatic read_status(input logic [1:0] a, input bit two,
                             output logic [7:0] s0, output logic [7:0] s1);
    logic ack;
    s1 = '0;
    bus_start();
    put_byte({5'b11000, a, 1'b1}, ack);
    chk("R1 read address ack", 32'(ack), 32'd1);
    get_byte(two, s0);
    if (two) get_byte(1'b0, s1);
    bus_stop();
  endtask

  task automatic write_n(input logic [1:0] a, input logic [7:0] d0, d1, d2, d3, d4,
                         input int n, output logic [5:0] acks);
    logic ack;
    logic [7:0] d [5];
    d = '{d0, d1, d2, d3, d4};
    acks = '0;
    bus_start();
    put_byte({5'b11000, a, 1'b0}, ack);
    acks[0] = ack;
    for (int k = 0; k < n; k++) begin
      put_byte(d[k], ack);
      acks[k+1] = ack;
    end
    bus_stop();
  endtask

  task automatic model(input logic [7:0] d0, d1, d2, d3, input int n);
    if (n >= 1) begin e_presc = d0[7]; e_cp = d0[6:5]; e_ref = d0[4:1]; end
    if (n >= 3) e_ratio = {d0[0], d1, d2};
    if (n >= 4) begin e_pull = d3[7:4]; e_aux = d3[3:2]; e_test = d3[1:0]; end
  endtask

  task automatic cmp_out(input string tag);
    chk({tag, " R2 mode fields"}, {presc, cp, ref_sel}, {e_presc, e_cp, e_ref});
    chk({tag, " R3 ratio"}, 32'(ratio), 32'(e_ratio));
    chk({tag, " R4 port/aux/test"}, {pull, aux, test}, {e_pull, e_aux, e_test});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] s0, s1, b0, b1, b2, b3;
    logic [5:0] acks;
    logic       ack;
    logic [16:0] r;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    addr_sel = 2'd0; lock = 1'b0; pin = 3'd0; adc = 3'd0;
    e_ratio = '0; e_ref = '0; e_pull = '0; e_presc = 1'b0; e_cp = '0; e_aux = '0; e_test = '0;
    repeat (5) @(negedge clk);
    chk("R9 sda during reset", 32'(sda_oe), 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 sda after reset", 32'(sda_oe), 32'd0);
    cmp_out("R9 reset");

    // R8/R6: first read carries power-on flag
    lock = 1'b1; pin = 3'b101; adc = 3'd3;
    read_status(2'd0, 1'b0, s0, s1);
    chk("R8 power-on flag set", 32'(s0[7]), 32'd1);
    chk("R6 status layout", 32'(s0), 32'hEB);
    chk("R10 released after stop", 32'(sda_oe), 32'd0);
    read_status(2'd0, 1'b0, s0, s1);
    chk("R8 power-on flag cleared", 32'(s0[7]), 32'd0);

    // R1: strap x address sweep
    for (int s = 0; s < 4; s++) begin
      for (int a = 0; a < 4; a++) begin
        addr_sel = 2'(s);
        bus_start();
        put_byte({5'b11000, 2'(a), 1'b0}, ack);
        bus_stop();
        chk("R1 address match", 32'(ack), 32'(a == s));
        chk("R10 released after stop", 32'(sda_oe), 32'd0);
      end
    end
    addr_sel = 2'd0;
    bus_start();
    put_byte(8'hA0, ack);
    bus_stop();
    chk("R1 wrong prefix", 32'(ack), 32'd0);

    // R2/R3/R4/R5: full frames
    addr_sel = 2'd2;
    for (int k = 0; k < 6; k++) begin
      r  = 17'((k * 23456 + 77) % 131072);
      b0 = {1'(k), 2'(k >> 1), 4'(k * 3 + 1), r[16]};
      b1 = r[15:8];
      b2 = r[7:0];
      b3 = {4'(k * 5 + 2), 2'(k), 2'(k + 1)};
      write_n(2'd2, b0, b1, b2, b3, 8'h00, 4, acks);
      chk("R5 data bytes acked", 32'(acks), 32'h1F);
      model(b0, b1, b2, b3, 4);
      cmp_out("full frame");
    end

    // R1: data after a mismatched address is ignored
    write_n(2'd1, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00, 4, acks);
    chk("R1 mismatched frame not acked", 32'(acks), 32'h00);
    cmp_out("R1 mismatch ignored");

    // R3: truncated frame keeps the ratio, R2 fields still update
    write_n(2'd2, 8'b1_10_0110_1, 8'h5A, 8'h00, 8'h00, 8'h00, 2, acks);
    chk("R5 two bytes acked", 32'(acks), 32'h07);
    model(8'b1_10_0110_1, 8'h5A, 8'h00, 8'h00, 2);
    cmp_out("R3 truncated");

    // R5: fifth data byte is refused and has no effect
    write_n(2'd2, 8'h3C, 8'h12, 8'h34, 8'hA5, 8'hFF, 5, acks);
    chk("R5 extra byte not acked", 32'(acks), 32'h1F);
    model(8'h3C, 8'h12, 8'h34, 8'hA5, 4);
    cmp_out("R5 extra byte");

    // R6/R7: converter code and port sweep
    for (int v = 0; v < 8; v++) begin
      lock = 1'(v >> 1);
      pin  = 3'(v ^ 5);
      adc  = 3'(v);
      read_status(2'd2, 1'b0, s0, s1);
      chk("R7 converter code", 32'(s0[2:0]), 32'((v > 4) ? 4 : v));
      chk("R6 status byte", 32'(s0), 32'({1'b0, 1'(v >> 1), 3'(v ^ 5), 3'((v > 4) ? 4 : v)}));
    end

    // R6: master ack gives another status byte
    lock = 1'b0; pin = 3'b011; adc = 3'd6;
    read_status(2'd2, 1'b1, s0, s1);
    chk("R6 first byte", 32'(s0), 32'h1C);
    chk("R6 repeated byte", 32'(s1), 32'h1C);
    chk("R10 released after stop", 32'(sda_oe), 32'd0);
    cmp_out("after reads");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule